// File: doc/BRIEF.md
# Panel Register Write Sequencer

This block drives the serial control port of a display panel controller. It turns a short power command into a fixed list of register writes and clocks each write out over a four-wire serial link in SPI mode 0. Each write is two separate 24-bit frames: an index frame that selects the register, then a data frame that carries the 16-bit value. Every frame opens with its own prefix byte.

Three start pulses pick the sequence. The power-up sequence turns the panel on and then programs its scan and colour-order setup. The resume sequence programs the setup first and then turns the panel on. The power-down sequence, which also serves for suspend, only puts the panel into shutdown. A 4-bit mode input chooses the scan direction and colour order used in the setup write. Mode is captured when a sequence is accepted.

The control FSM has four states. IDLE waits for a start. On any start pulse it latches the sequence and mode, resets the step count and moves to LOAD. LOAD hands the current frame to the shifter and always moves to SHIFT. SHIFT waits for the shifter's frame-finished strobe and then moves to STEP. In STEP, the last frame of the sequence returns the FSM to IDLE. Any other frame advances the step count and returns to LOAD. A serial shifter clocks each frame out, and a combinational frame table builds each frame from the sequence, the step and the latched mode.

Top module: `panel_cmd_seq`

## Requirements
- R1: An index frame is 24 bits: 0x74, then 0x00, then the register number.
- R2: A data frame is 24 bits: 0x76, then the high byte of the value, then the low byte.
- R3: A power-up sequence (start_up) sends four frames. They are the index and data frames for register 0x11 with value 0x0000, then the index and data frames for register 0x01 with the setup value.
- R4: A resume sequence (start_resume) sends four frames. They are the index and data frames for register 0x01 with the setup value, then the index and data frames for register 0x11 with value 0x0000.
- R5: A power-down sequence (start_down) sends only two frames: the index frame for register 0x11 and a data frame with value 0x0001.
- R6: The setup value is 0x00EF ORed with the mode bits at fixed positions. mode[0] (left/right) goes to bit 14, mode[1] (top/bottom) to bit 9, mode[2] (colour order) to bit 11 and mode[3] (reverse) to bit 13. So mode 0xF gives 0x6AEF.
- R7: The link runs in SPI mode 0. sclk is low whenever cs_n is high. Bits go out MSB first. mosi does not change while sclk is high.
- R8: cs_n goes low for exactly 24 sclk rising edges per frame and returns high between frames. cs_n is high whenever busy is low.
- R9: busy rises in the cycle after an accepted start and stays high until the last frame has finished. done is high for exactly one cycle, which is the final busy cycle.
- R10: Start pulses and mode changes that arrive while busy is high have no effect on the running sequence, and they do not start another one.
- R11: If start pulses arrive together, power-up wins over resume, and resume wins over power-down.
- R12: After reset, cs_n is high, sclk is low, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_up | input | 1 | Pulse to start the power-up sequence |
| start_down | input | 1 | Pulse to start the power-down / suspend sequence |
| start_resume | input | 1 | Pulse to start the resume sequence |
| mode | input | 4 | Scan direction and colour order used in the setup write |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the panel |
| cs_n | output | 1 | Active-low chip select, one low window per frame |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bound checker tests the signalling rules on every cycle. It checks that sclk stays low outside a frame, that mosi holds steady while sclk is high, and that chip select stays inactive when the block is idle. It also checks that busy rises after an accepted start and holds until done, and that done lasts one cycle and ends busy. Other behaviours can only be shown by the bench's scenarios, which decode each frame from the serial pins and compare it with a list built from the requirements. These include the byte content of each frame, the frame order within each sequence, the setup value for each mode, start priority, and the fact that starts and mode changes are ignored during a sequence.

// File: rtl/pnl_pkg.sv
package pnl_pkg;

    typedef enum logic [1:0] {
        SEQ_UP     = 2'd0,
        SEQ_DOWN   = 2'd1,
        SEQ_RESUME = 2'd2
    } seq_e;

    localparam int FRAME_W = 24;

    localparam logic [7:0]  PFX_INDEX = 8'h74;
    localparam logic [7:0]  PFX_DATA  = 8'h76;
    localparam logic [7:0]  REG_SHUT  = 8'h11;
    localparam logic [7:0]  REG_SETUP = 8'h01;
    localparam logic [15:0] SETUP_BASE = 16'h2AEF;

    localparam int POS_LR  = 14;
    localparam int POS_TB  = 9;
    localparam int POS_BGR = 11;
    localparam int POS_REV = 13;

    function automatic logic [15:0] setup_value(input logic [3:0] m);
        logic [15:0] mask;
        logic [15:0] sel;
        mask = '0;
        sel  = '0;
        mask[POS_LR]  = 1'b1;
        mask[POS_TB]  = 1'b1;
        mask[POS_BGR] = 1'b1;
        mask[POS_REV] = 1'b1;
        sel[POS_LR]   = m[0];
        sel[POS_TB]   = m[1];
        sel[POS_BGR]  = m[2];
        sel[POS_REV]  = m[3];
        return (SETUP_BASE & ~mask) | sel;
    endfunction

endpackage

// File: rtl/pnl_frame_rom.sv
module pnl_frame_rom
    import pnl_pkg::*;
(
    input  seq_e                 seq,
    input  logic [1:0]           step,
    input  logic [3:0]           mode,
    output logic [FRAME_W-1:0]   word,
    output logic                 last
);

    logic [7:0]  reg_sel;
    logic [15:0] value;

    always_comb begin
        unique case (seq)
            SEQ_UP:     reg_sel = step[1] ? REG_SETUP : REG_SHUT;
            SEQ_RESUME: reg_sel = step[1] ? REG_SHUT  : REG_SETUP;
            default:    reg_sel = REG_SHUT;
        endcase

        if (reg_sel == REG_SETUP)
            value = setup_value(mode);
        else
            value = (seq == SEQ_DOWN) ? 16'h0001 : 16'h0000;

        word = step[0] ? {PFX_DATA, value} : {PFX_INDEX, 8'h00, reg_sel};
        last = (seq == SEQ_DOWN) ? (step == 2'd1) : (step == 2'd3);
    end

endmodule

// File: rtl/pnl_spi_shift.sv
module pnl_spi_shift #(
    parameter int HALF_CYC = 2,
    parameter int GAP_CYC  = 2,
    parameter int FRAME_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] word,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic               fin
);

    localparam int CNT_MAX = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_W - 1);

    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bitn;
    logic [FRAME_W-1:0] shreg;
    logic               active;
    logic               gapping;

    assign mosi = shreg[FRAME_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            active  <= 1'b0;
            gapping <= 1'b0;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (active) begin
                if (cnt == HALF_LAST) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk <= 1'b1;
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == BIT_LAST) begin
                            active  <= 1'b0;
                            gapping <= 1'b1;
                            cs_n    <= 1'b1;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            shreg <= {shreg[FRAME_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (gapping) begin
                if (cnt == GAP_LAST) begin
                    cnt     <= '0;
                    gapping <= 1'b0;
                    fin     <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (go) begin
                shreg  <= word;
                cs_n   <= 1'b0;
                sclk   <= 1'b0;
                active <= 1'b1;
                cnt    <= '0;
                bitn   <= '0;
            end
        end
    end

endmodule

// File: rtl/panel_cmd_seq.sv
module panel_cmd_seq
    import pnl_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int GAP_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_up,
    input  logic       start_down,
    input  logic       start_resume,
    input  logic [3:0] mode,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    output logic       busy,
    output logic       done
);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_STEP  = 2'd3
    } state_e;

    state_e             state;
    state_e             nxt;
    seq_e               seq_q;
    seq_e               seq_pick;
    logic [3:0]         mode_q;
    logic [1:0]         step_q;
    logic [FRAME_W-1:0] word;
    logic               last;
    logic               go;
    logic               fin;
    logic               any_start;

    assign any_start = start_up | start_down | start_resume;

    always_comb begin
        if (start_up)
            seq_pick = SEQ_UP;
        else if (start_resume)
            seq_pick = SEQ_RESUME;
        else
            seq_pick = SEQ_DOWN;
    end

    pnl_frame_rom u_rom (
        .seq  (seq_q),
        .step (step_q),
        .mode (mode_q),
        .word (word),
        .last (last)
    );

    pnl_spi_shift #(
        .HALF_CYC (HALF_CYC),
        .GAP_CYC  (GAP_CYC),
        .FRAME_W  (FRAME_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .word  (word),
        .sclk  (sclk),
        .mosi  (mosi),
        .cs_n  (cs_n),
        .fin   (fin)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (any_start) nxt = ST_LOAD;
            ST_LOAD:  nxt = ST_SHIFT;
            ST_SHIFT: if (fin) nxt = ST_STEP;
            ST_STEP:  nxt = last ? ST_IDLE : ST_LOAD;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q  <= SEQ_DOWN;
            mode_q <= '0;
            step_q <= '0;
        end else if (state == ST_IDLE && any_start) begin
            seq_q  <= seq_pick;
            mode_q <= mode;
            step_q <= '0;
        end else if (state == ST_STEP && !last) begin
            step_q <= step_q + 1'b1;
        end
    end

    always_comb begin
        go   = (state == ST_LOAD);
        busy = (state != ST_IDLE);
        done = (state == ST_STEP) && last;
    end

endmodule

// File: rtl/pnl_cmd_seq_chk.sv
module pnl_cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_up,
    input logic start_down,
    input logic start_resume,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic busy,
    input logic done
);

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R7

    AST_MOSI_HELD_HIGH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk) |-> $stable(mosi)); // R7

    AST_CS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n); // R8

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (start_up || start_down || start_resume)) |=> busy); // R9

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R9

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done)); // R9

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R9

endmodule

bind panel_cmd_seq pnl_cmd_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_up     (start_up),
    .start_down   (start_down),
    .start_resume (start_resume),
    .sclk         (sclk),
    .mosi         (mosi),
    .cs_n         (cs_n),
    .busy         (busy),
    .done         (done)
);

// File: tb/panel_cmd_seq_test.sv
module panel_cmd_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_up = 1'b0;
    logic       start_down = 1'b0;
    logic       start_resume = 1'b0;
    logic [3:0] mode = 4'h0;
    logic       sclk, mosi, cs_n, busy, done;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    panel_cmd_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_up     (start_up),
        .start_down   (start_down),
        .start_resume (start_resume),
        .mode         (mode),
        .sclk         (sclk),
        .mosi         (mosi),
        .cs_n         (cs_n),
        .busy         (busy),
        .done         (done)
    );

    // serial decoder built on the pins only
    logic [23:0] sh;
    int          nbits;
    logic [23:0] frames [0:7];
    int          fcnt;
    int          badbits;
    int          dn;
    int          sclk_bad;

    always @(posedge sclk) if (rst_n && !cs_n) begin
        sh = {sh[22:0], mosi};
        nbits = nbits + 1;
    end

    always @(negedge cs_n) nbits = 0;

    always @(posedge cs_n) if (rst_n) begin
        if (nbits != 24) badbits = badbits + 1;
        if (fcnt < 8) frames[fcnt] = sh;
        fcnt = fcnt + 1;
    end

    always @(negedge clk) if (rst_n) begin
        if (done) dn = dn + 1;
        if (cs_n && sclk) sclk_bad = sclk_bad + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_setup(input logic [3:0] m);
        logic [15:0] v;
        v = 16'h00EF;
        if (m[0]) v = v | 16'h4000;
        if (m[1]) v = v | 16'h0200;
        if (m[2]) v = v | 16'h0800;
        if (m[3]) v = v | 16'h2000;
        return v;
    endfunction

    function automatic logic [23:0] exp_frame(input int kind, input logic [3:0] m, input int idx);
        logic [7:0]  r;
        logic [15:0] v;
        bit          second;
        second = (idx >= 2);
        if (kind == 0)      r = second ? 8'h01 : 8'h11;
        else if (kind == 2) r = second ? 8'h11 : 8'h01;
        else                r = 8'h11;
        if (r == 8'h01)     v = exp_setup(m);
        else                v = (kind == 1) ? 16'h0001 : 16'h0000;
        return (idx % 2 == 1) ? {8'h76, v} : {8'h74, 8'h00, r};
    endfunction

    // kind: 0 power-up, 1 power-down, 2 resume; starts = {resume, down, up}
    task automatic run(input int kind, input logic [2:0] starts, input logic [3:0] m, input bit disturb);
        int    n;
        int    guard;
        string stag;
        fcnt = 0; dn = 0; badbits = 0;
        @(negedge clk);
        mode = m;
        start_up = starts[0]; start_down = starts[1]; start_resume = starts[2];
        @(negedge clk);
        start_up = 0; start_down = 0; start_resume = 0;
        chk(busy == 1'b1, "R9 busy after start", {31'd0, busy}, 32'd1);
        if (disturb) begin
            repeat (150) @(negedge clk);
            mode = ~m;
            start_up = 1; start_down = 1; start_resume = 1;
            @(negedge clk);
            start_up = 0; start_down = 0; start_resume = 0;
        end
        guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (6) @(negedge clk);
        n = (kind == 1) ? 2 : 4;
        stag = (kind == 0) ? "R3" : (kind == 1) ? "R5" : "R2/R4";
        if (disturb) stag = "R10";
        if (starts != 3'b001 && starts != 3'b010 && starts != 3'b100) stag = "R11";
        chk(fcnt == n, {stag, " frame count"}, fcnt, n);
        for (int i = 0; i < n && i < 8; i++) begin
            logic [23:0] e;
            e = exp_frame(kind, m, i);
            if (i % 2 == 0)
                chk(frames[i] == e, {stag, " R1 index frame"}, {8'd0, frames[i]}, {8'd0, e});
            else if (e[15:0] != 16'h0000 && e[15:0] != 16'h0001)
                chk(frames[i] == e, {stag, " R6 setup data frame"}, {8'd0, frames[i]}, {8'd0, e});
            else
                chk(frames[i] == e, {stag, " R2 data frame"}, {8'd0, frames[i]}, {8'd0, e});
        end
        chk(badbits == 0, "R8 bits per frame", badbits, 0);
        chk(dn == 1, "R9 done pulse count", dn, 1);
        chk(busy == 1'b0, "R9 busy low after done", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        sh = '0; nbits = 0; fcnt = 0; badbits = 0; dn = 0; sclk_bad = 0;
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1, "R12 cs_n reset", {31'd0, cs_n}, 32'd1);
        chk(sclk == 1'b0, "R12 sclk reset", {31'd0, sclk}, 32'd0);
        chk(busy == 1'b0, "R12 busy reset", {31'd0, busy}, 32'd0);
        chk(done == 1'b0, "R12 done reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run(0, 3'b001, 4'hF, 0);   // R3 R6 all mode bits
        run(2, 3'b100, 4'h0, 0);   // R4 no mode bits
        run(1, 3'b010, 4'h5, 0);   // R5 mode irrelevant
        run(0, 3'b011, 4'h2, 0);   // R11 up beats down
        run(2, 3'b110, 4'h8, 0);   // R11 resume beats down
        run(0, 3'b111, 4'h4, 0);   // R11 up beats all
        run(2, 3'b100, 4'h1, 1);   // R10 starts and mode change while busy
        run(1, 3'b010, 4'h3, 1);   // R10

        for (int k = 0; k < 30; k++) begin
            int          kind;
            logic [3:0]  m;
            logic [2:0]  st;
            kind = int'($urandom % 3);
            m    = 4'($urandom);
            st   = (kind == 0) ? 3'b001 : (kind == 1) ? 3'b010 : 3'b100;
            run(kind, st, m, ($urandom % 4) == 0);
        end

        chk(sclk_bad == 0, "R7 sclk low while deselected", sclk_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule